// File: doc/BRIEF.md
# Free-Running Capture/Compare Timer

A 16-bit up-counter that starts from zero when it is enabled in free-running mode. It advances by one on every count tick and wraps from 0xFFFF back to 0x0000. The count tick comes from one of two places. The first is an internal prescaled tick input. The second is a synchronized, edge-detected external event input. Four channel registers sit beside the counter, and each one is set as a compare or a capture register by its own select bit.

A compare channel raises its interrupt pulse when the counter reaches the value in its register, and it toggles its timer output at the same time. A capture channel copies the counter into its register when its trigger input shows the chosen edge, and it pulses its interrupt. An overflow interrupt marks each wrap of the counter. Software loads the channel registers through a write port. A combinational read port returns any channel register or the live counter.

Top module: `frc_timer`

## Requirements
- R1: The counter runs only while `cntEnable` is 1 and `modeSel` equals 3'b101. Otherwise the counter is held at 0, `timerOut`, `chanIrq` and `ovfIrq` are held low, and the channel registers keep their values. All of these are 0 after reset.
- R2: When the internal source is selected (`clkSrcExt`=0), the counter increments by one on each clock edge where `tickIn` is 1. It holds its value on edges where `tickIn` is 0.
- R3: When the external source is selected (`clkSrcExt`=1), `tickIn` is ignored. `evtIn` passes through two synchronizer flops and an edge detector set by `evtEdgeCfg`. If `evtIn` changes before clock edge k and the change matches the configured edge, the counter has incremented after edge k+2.
- R4: A tick at 0xFFFF sets the counter to 0x0000. `ovfIrq` is high for exactly the one cycle in which the counter first reads 0.
- R5: A compare channel (its `chanCapSel` bit is 0) pulses its `chanIrq` bit for one cycle and toggles its `timerOut` bit when a tick moves the counter onto that channel's register value. The pulse and the toggle appear in the same cycle as the new count.
- R6: A capture channel (its `chanCapSel` bit is 1) watches its trigger input. If the trigger changes before edge k and the change matches the configured edge, the channel's register holds the counter value from before edge k+2 once that edge has passed, and `chanIrq` pulses in the following cycle.
- R7: A channel in capture mode drives its `timerOut` bit low from the edge after its select bit is set.
- R8: With `wrEn`=1, a clock edge writes `wrData` into channel `wrAddr`. `rdData` is combinational: `rdAddr` 0 to 3 returns a channel register, 4 returns the counter, and 5 to 7 return 0.
- R9: Every edge configuration uses the same encoding: 00 = no edge, 01 = rising, 10 = falling, 11 = both. The configuration for trigger i is `trigEdgeCfg[2i+1:2i]`. An edge that does not match the configuration neither counts nor captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cntEnable | input | 1 | Count enable |
| modeSel | input | 3 | Mode field; 3'b101 selects free-running |
| clkSrcExt | input | 1 | 1 selects the external event as count source |
| tickIn | input | 1 | Internal prescaled count tick |
| evtIn | input | 1 | Asynchronous external event input |
| evtEdgeCfg | input | 2 | Edge selection for evtIn |
| chanCapSel | input | 4 | Per-channel select, 1 = capture, 0 = compare |
| trigIn | input | 4 | Asynchronous capture trigger inputs |
| trigEdgeCfg | input | 8 | Two edge-selection bits per trigger |
| wrEn | input | 1 | Channel register write strobe |
| wrAddr | input | 2 | Channel to write |
| wrData | input | 16 | Write data |
| rdAddr | input | 3 | Read select |
| rdData | output | 16 | Read data |
| timerOut | output | 4 | Channel outputs |
| chanIrq | output | 4 | Channel interrupt pulses |
| ovfIrq | output | 1 | Overflow interrupt pulse |

## Verification
Internal ticks, register writes and mode changes take effect at the first clock edge after they are driven. Asynchronous event and trigger changes take effect at the third edge after they are driven, once they have crossed two synchronizer flops and an edge register. The driver changes inputs just after a rising edge and counts edges to the one where each result is due. It then queues the expected value, and the monitor compares that value at the next falling edge. The bench checks the cycle before a due capture as well, so a result that arrives early is reported.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int CNT_W = 16;
  localparam int NCH = 4;
  localparam int SYNC_LEN = 2;
  localparam int ADDR_W = $clog2(NCH);
  localparam int RD_W = ADDR_W + 1;
  localparam logic [2:0] MODE_FREE = 3'b101;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edgeSel_t;

  typedef struct packed {
    logic run;
    logic tick;
    logic [NCH-1:0] capStb;
  } frcStrobe_t;
endpackage

// File: rtl/frc_edge.sv
module frc_edge
  import frc_pkg::*;
#(
  parameter int SYNC_STAGES = SYNC_LEN
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinIn,
  input  logic [1:0] cfg,
  output logic       pulse
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic lastQ;
  logic syncBit;
  logic riseSeen;
  logic fallSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      lastQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
      lastQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign syncBit  = syncQ[SYNC_STAGES-1];
  assign riseSeen = syncBit & ~lastQ;
  assign fallSeen = ~syncBit & lastQ;

  always_comb begin
    unique case (edgeSel_t'(cfg))
      EDGE_RISE: pulse = riseSeen;
      EDGE_FALL: pulse = fallSeen;
      EDGE_BOTH: pulse = riseSeen | fallSeen;
      default:   pulse = 1'b0;
    endcase
  end

  // R9: a disabled detector never fires
  p_cfg_none_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfg == 2'b00) |-> !pulse);
endmodule

// File: rtl/frc_ctrl.sv
module frc_ctrl
  import frc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEnable,
  input  logic [2:0]       modeSel,
  input  logic             clkSrcExt,
  input  logic             tickIn,
  input  logic             evtIn,
  input  logic [1:0]       evtEdgeCfg,
  input  logic [NCH-1:0]   chanCapSel,
  input  logic [NCH-1:0]   trigIn,
  input  logic [2*NCH-1:0] trigEdgeCfg,
  output frcStrobe_t       stb
);
  logic evtPulse;
  logic [NCH-1:0] trigPulse;
  logic runNow;

  frc_edge u_evtEdge (
    .clk(clk), .rstN(rstN), .pinIn(evtIn), .cfg(evtEdgeCfg), .pulse(evtPulse)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_trig
    frc_edge u_trigEdge (
      .clk(clk), .rstN(rstN), .pinIn(trigIn[i]),
      .cfg(trigEdgeCfg[2*i+1:2*i]), .pulse(trigPulse[i])
    );
  end

  assign runNow     = cntEnable && (modeSel == MODE_FREE);
  assign stb.run    = runNow;
  assign stb.tick   = runNow && (clkSrcExt ? evtPulse : tickIn);
  assign stb.capStb = {NCH{runNow}} & chanCapSel & trigPulse;

  // R3: with the event source chosen, the tick input alone cannot count
  p_ext_ignores_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    (clkSrcExt && !evtPulse) |-> !stb.tick);
endmodule

// File: rtl/frc_dpath.sv
module frc_dpath
  import frc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  frcStrobe_t        stb,
  input  logic [NCH-1:0]    chanCapSel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [RD_W-1:0]   rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic [NCH-1:0]    timerOut,
  output logic [NCH-1:0]    chanIrq,
  output logic              ovfIrq
);
  localparam logic [RD_W-1:0] CNT_SEL = RD_W'(NCH);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] chanReg [NCH];

  assign cntNext = cntQ + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      ovfIrq <= 1'b0;
    end else begin
      ovfIrq <= stb.tick && (cntQ == '1);
      if (!stb.run) cntQ <= '0;
      else if (stb.tick) cntQ <= cntNext;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic cmpHit;
    logic irqQ;
    logic outQ;

    assign cmpHit = stb.tick && !chanCapSel[i] && (cntNext == chanReg[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chanReg[i] <= '0;
        irqQ       <= 1'b0;
        outQ       <= 1'b0;
      end else begin
        if (stb.capStb[i]) chanReg[i] <= cntQ;
        else if (wrEn && (wrAddr == ADDR_W'(i))) chanReg[i] <= wrData;
        irqQ <= cmpHit || stb.capStb[i];
        if (!stb.run || chanCapSel[i]) outQ <= 1'b0;
        else if (cmpHit) outQ <= ~outQ;
      end
    end

    assign chanIrq[i]  = irqQ;
    assign timerOut[i] = outQ;

    // R7: a capture channel never drives its output
    p_cap_out_low_r7: assert property (@(posedge clk) disable iff (!rstN)
      chanCapSel[i] |=> !timerOut[i]);
    // R5: a match pulses the interrupt and flips the output
    p_cmp_toggle_r5: assert property (@(posedge clk) disable iff (!rstN)
      (stb.tick && !chanCapSel[i] && (cntNext == chanReg[i]))
        |=> (chanIrq[i] && (timerOut[i] != $past(timerOut[i]))));
  end

  always_comb begin
    if (rdAddr < CNT_SEL) rdData = chanReg[rdAddr[ADDR_W-1:0]];
    else if (rdAddr == CNT_SEL) rdData = cntQ;
    else rdData = '0;
  end

  // R1: a stopped timer sits at zero
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    !stb.run |=> (cntQ == '0));
  // R2: no tick, no movement
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.run && !stb.tick) |=> $stable(cntQ));
  // R4: wrap to zero with an overflow pulse
  p_wrap_ovf_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.tick && (cntQ == '1)) |=> (ovfIrq && (cntQ == '0)));
endmodule

// File: rtl/frc_timer.sv
module frc_timer
  import frc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEnable,
  input  logic [2:0]       modeSel,
  input  logic             clkSrcExt,
  input  logic             tickIn,
  input  logic             evtIn,
  input  logic [1:0]       evtEdgeCfg,
  input  logic [3:0]       chanCapSel,
  input  logic [3:0]       trigIn,
  input  logic [7:0]       trigEdgeCfg,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [15:0]      wrData,
  input  logic [2:0]       rdAddr,
  output logic [15:0]      rdData,
  output logic [3:0]       timerOut,
  output logic [3:0]       chanIrq,
  output logic             ovfIrq
);
  frcStrobe_t stb;

  frc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cntEnable(cntEnable), .modeSel(modeSel),
    .clkSrcExt(clkSrcExt), .tickIn(tickIn), .evtIn(evtIn),
    .evtEdgeCfg(evtEdgeCfg), .chanCapSel(chanCapSel), .trigIn(trigIn),
    .trigEdgeCfg(trigEdgeCfg), .stb(stb)
  );

  frc_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .chanCapSel(chanCapSel),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .timerOut(timerOut), .chanIrq(chanIrq), .ovfIrq(ovfIrq)
  );
endmodule

// File: tb/frc_timer_tb.sv
module frc_timer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cntEnable = 1'b0;
  logic [2:0] modeSel = 3'b000;
  logic clkSrcExt = 1'b0;
  logic tickIn = 1'b0;
  logic evtIn = 1'b0;
  logic [1:0] evtEdgeCfg = 2'b00;
  logic [3:0] chanCapSel = 4'b0000;
  logic [3:0] trigIn = 4'b0000;
  logic [7:0] trigEdgeCfg = 8'h00;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = 2'b00;
  logic [15:0] wrData = 16'h0000;
  logic [2:0] rdAddr = 3'd4;
  logic [15:0] rdData;
  logic [3:0] timerOut;
  logic [3:0] chanIrq;
  logic ovfIrq;

  localparam int K_RD = 0, K_IRQ = 1, K_OVF = 2, K_OUT = 3;

  typedef struct {
    string tag;
    int kind;
    int exp;
  } item_t;

  item_t sbq[$];
  item_t it;
  int act;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  frc_timer u_dut (
    .clk(clk), .rstN(rstN), .cntEnable(cntEnable), .modeSel(modeSel),
    .clkSrcExt(clkSrcExt), .tickIn(tickIn), .evtIn(evtIn),
    .evtEdgeCfg(evtEdgeCfg), .chanCapSel(chanCapSel), .trigIn(trigIn),
    .trigEdgeCfg(trigEdgeCfg), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .timerOut(timerOut), .chanIrq(chanIrq),
    .ovfIrq(ovfIrq)
  );

  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      it = sbq.pop_front();
      case (it.kind)
        K_RD:    act = int'(rdData);
        K_IRQ:   act = int'(chanIrq);
        K_OVF:   act = int'(ovfIrq);
        default: act = int'(timerOut);
      endcase
      total++;
      if (act != it.exp) begin
        bad++;
        $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expectVal(string tag, int kind, int exp);
    item_t e;
    e.tag = tag;
    e.kind = kind;
    e.exp = exp;
    sbq.push_back(e);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(2);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    expectVal("R1", K_RD, 0);
    expectVal("R1", K_IRQ, 0);
    expectVal("R1", K_OVF, 0);
    expectVal("R1", K_OUT, 0);

    // R8 register writes and read decode
    wrEn = 1'b1; wrAddr = 2'd0; wrData = 16'd5;
    step(1);
    wrAddr = 2'd1; wrData = 16'd3;
    step(1);
    wrEn = 1'b0; rdAddr = 3'd0;
    expectVal("R8", K_RD, 5);
    step(1);
    rdAddr = 3'd1;
    expectVal("R8", K_RD, 3);
    step(1);
    rdAddr = 3'd6;
    expectVal("R8", K_RD, 0);
    step(1);

    // R1 wrong mode keeps the counter at zero
    rdAddr = 3'd4; cntEnable = 1'b1; modeSel = 3'b000; tickIn = 1'b1;
    step(3);
    expectVal("R1", K_RD, 0);

    // R2 / R5 counting and compare matches
    modeSel = 3'b101;
    step(1);
    expectVal("R2", K_RD, 1);
    step(2);
    expectVal("R5", K_RD, 3);
    expectVal("R5", K_IRQ, 4'b0010);
    expectVal("R5", K_OUT, 4'b0010);
    step(1);
    expectVal("R5", K_IRQ, 0);
    step(1);
    expectVal("R5", K_RD, 5);
    expectVal("R5", K_IRQ, 4'b0001);
    expectVal("R5", K_OUT, 4'b0011);

    // R2 hold without tick, single ticks
    tickIn = 1'b0;
    step(3);
    expectVal("R2", K_RD, 5);
    tickIn = 1'b1;
    step(1);
    expectVal("R2", K_RD, 6);
    tickIn = 1'b0;
    step(1);
    expectVal("R2", K_RD, 6);

    // R4 wrap; channels 2 and 3 hold 0 so they match on the wrap (R5)
    tickIn = 1'b1;
    step(65529);
    expectVal("R4", K_RD, 16'hFFFF);
    expectVal("R4", K_OVF, 0);
    step(1);
    expectVal("R4", K_RD, 0);
    expectVal("R4", K_OVF, 1);
    expectVal("R5", K_IRQ, 4'b1100);
    expectVal("R5", K_OUT, 4'b1111);
    step(1);
    expectVal("R4", K_OVF, 0);
    expectVal("R4", K_RD, 1);

    // R1 disable clears counter and outputs, keeps registers
    cntEnable = 1'b0; tickIn = 1'b0;
    step(1);
    expectVal("R1", K_RD, 0);
    expectVal("R1", K_OUT, 0);
    step(1);
    rdAddr = 3'd0;
    expectVal("R1", K_RD, 5);
    step(1);

    // R7 / R6 capture on channel 1
    rdAddr = 3'd4; cntEnable = 1'b1; tickIn = 1'b1;
    step(7);
    tickIn = 1'b0;
    expectVal("R2", K_RD, 7);
    expectVal("R5", K_OUT, 4'b0011);
    chanCapSel = 4'b0010; trigEdgeCfg = 8'b0000_0100;
    step(1);
    expectVal("R7", K_OUT, 4'b0001);
    trigIn = 4'b0010;
    step(2);
    expectVal("R6", K_IRQ, 0);
    step(1);
    rdAddr = 3'd1;
    expectVal("R6", K_IRQ, 4'b0010);
    expectVal("R6", K_RD, 7);
    step(1);
    rdAddr = 3'd4; tickIn = 1'b1;
    step(1);
    tickIn = 1'b0;
    expectVal("R2", K_RD, 8);
    // R9 falling edge ignored under rising-only setting
    trigIn = 4'b0000;
    step(3);
    rdAddr = 3'd1;
    expectVal("R9", K_IRQ, 0);
    expectVal("R9", K_RD, 7);
    step(1);
    // R6 both-edge setting captures the rising edge
    trigEdgeCfg = 8'b0000_1100; trigIn = 4'b0010;
    step(3);
    expectVal("R6", K_IRQ, 4'b0010);
    expectVal("R6", K_RD, 8);
    step(1);
    // R9 no-edge setting blocks capture
    trigEdgeCfg = 8'h00; trigIn = 4'b0000;
    step(3);
    expectVal("R9", K_IRQ, 0);
    expectVal("R9", K_RD, 8);
    step(1);

    // R3 external event source, falling edges only, tickIn ignored
    rdAddr = 3'd4; clkSrcExt = 1'b1; evtEdgeCfg = 2'b10; tickIn = 1'b1; evtIn = 1'b1;
    step(4);
    expectVal("R3", K_RD, 8);
    evtIn = 1'b0;
    step(2);
    expectVal("R3", K_RD, 8);
    step(1);
    expectVal("R3", K_RD, 9);
    evtEdgeCfg = 2'b11; evtIn = 1'b1;
    step(3);
    expectVal("R3", K_RD, 10);
    evtEdgeCfg = 2'b00; evtIn = 1'b0;
    step(4);
    expectVal("R9", K_RD, 10);

    @(negedge clk);
    #1;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule